// File: doc/BRIEF.md
# Bus-side snoop coincidence responder

This block is the bus-facing half of a page-associative cache controller. It holds one descriptor per cache frame, holding the physical page number. Descriptor i always belongs to the same frame as entry i of the processor-side array, which may hold logical tags. Beside each descriptor it keeps its own mirror of every line's valid, exclusive and owned bits. With that mirror it can answer bus snoops without touching the processor side.

On every bus address strobe the block decodes the start address. It first looks for a descriptor holding that physical page, then checks the addressed line. One cycle later it presents a registered cache-status answer. The cache-command input chooses the question being asked:
- With the command asserted, the transfer is a single line, and status reports whether that line is held.
- With the command deasserted, the transfer may span many lines inside one page, and status reports whether letting it run would break coherence.

When a snoop forces a change to this cache's attributes, the block updates its mirror. It also raises a request carrying the frame index and line number, so the processor side can act on its logically tagged entry without reverse translation.

The block is a two-state machine:
- ST_IDLE moves to ST_RESPOND on a strobe.
- ST_RESPOND stays in ST_RESPOND on a back-to-back strobe and returns to ST_IDLE otherwise.

Outputs are valid only in ST_RESPOND.

Top module: `snoop_responder`

## Requirements
- R1: After reset, rsp_valid, cs_o and req_valid are low and every descriptor is empty, so a snoop to any address answers cs_o=0 with no request.
- R2: rsp_valid is high in exactly the cycle after each cycle with bus_as high, including back-to-back strobes, and low otherwise; cs_o and the request outputs belong to that response.
- R3: A frame load (load_en) sets that frame's physical page and marks it present. It also clears all attribute bits of that frame. A load overrides any attribute update or snoop-driven change that targets the same frame in the same cycle.
- R4: An attribute update (upd_en) writes the valid, exclusive and owned bits of one line of one frame. A snoop in the same cycle is answered from the state before that update.
- R5: Address fields: page number = bus_addr[ADDR_W-1:PAGE_OFS_W], line = bus_addr[PAGE_OFS_W-1:LINE_OFS_W]. With bus_cc=1 and bus_inv=0, cs_o = page matched and the addressed line valid.
- R6: With bus_cc=0 and bus_inv=0, cs_o = page matched and (any line of the frame owned, or bus_wr=1 and any line of the frame valid). No request is raised and no attribute changes.
- R7: A single-line write (bus_cc=1, bus_wr=1) hitting a valid line clears its valid, exclusive and owned bits and raises req_kind=1 (line invalidate) with the frame and line.
- R8: A single-line read hitting a valid exclusive line clears only its exclusive bit and raises req_kind=2 (line downgrade). A read hit on a non-exclusive line raises no request.
- R9: bus_inv=1 takes precedence over bus_cc. On a page match it clears every line of the matched frame and raises req_kind=3 (page invalidate) with req_line=0. cs_o is 0 whether or not the page matches, and there is no request on a miss.
- R10: When an attribute update and a snoop-driven change target the same line in the same cycle, the snoop-driven change is applied last.
- R11: If several present descriptors hold the same page, the lowest frame index is the one matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load a frame descriptor |
| load_frame | input | $clog2(NUM_FRAMES) | Frame index to load |
| load_ppn | input | ADDR_W-PAGE_OFS_W | Physical page number for the frame |
| upd_en | input | 1 | Mirror an attribute change from the processor side |
| upd_frame | input | $clog2(NUM_FRAMES) | Frame of the attribute change |
| upd_line | input | PAGE_OFS_W-LINE_OFS_W | Line of the attribute change |
| upd_v | input | 1 | New valid bit |
| upd_x | input | 1 | New exclusive bit |
| upd_o | input | 1 | New owned bit |
| bus_as | input | 1 | Bus address strobe, one cycle per transaction |
| bus_addr | input | ADDR_W | Transaction start address |
| bus_cc | input | 1 | 1: single-line transfer; 0: multi-line within a page |
| bus_wr | input | 1 | Transaction is a write |
| bus_inv | input | 1 | Page invalidate command |
| rsp_valid | output | 1 | Response cycle for the previous strobe |
| cs_o | output | 1 | Cache-status answer |
| req_valid | output | 1 | Processor side must update attributes |
| req_kind | output | 2 | 1 line invalidate, 2 line downgrade, 3 page invalidate |
| req_frame | output | $clog2(NUM_FRAMES) | Matched frame index |
| req_line | output | PAGE_OFS_W-LINE_OFS_W | Matched line number |

## Verification
Two functions can land in the same cycle:
- a processor-side mirror write or frame load, and
- a snoop-driven attribute change to the same frame or line.

The bench provokes this by drawing pages, frames and lines from small pools, so random updates, loads and strobes collide often. Directed cycles add an update and a single-line write aimed at one line, and a load aimed at a frame being snooped. A bench model applies the update, then the snoop change, then the load. Later snoops to that line and page must match the model's response, and a single mismatch exposes a wrong order.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    typedef enum logic [1:0] {
        REQ_NONE       = 2'd0,
        REQ_LINE_INV   = 2'd1,
        REQ_LINE_SHARE = 2'd2,
        REQ_PAGE_INV   = 2'd3
    } req_kind_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RESPOND = 1'b1
    } snp_state_e;

endpackage

// File: rtl/snoop_tag_cam.sv
module snoop_tag_cam #(
    parameter int NF     = 8,
    parameter int PPN_W  = 22,
    parameter int FIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [FIDX_W-1:0] load_frame,
    input  logic [PPN_W-1:0]  load_ppn,
    input  logic [PPN_W-1:0]  look_ppn,
    output logic              hit,
    output logic [FIDX_W-1:0] hit_frame
);

    logic [NF-1:0] match;

    for (genvar g = 0; g < NF; g++) begin : g_desc
        logic             present_q;
        logic [PPN_W-1:0] ppn_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                present_q <= 1'b0;
                ppn_q     <= '0;
            end else if (load_en && load_frame == FIDX_W'(g)) begin
                present_q <= 1'b1;
                ppn_q     <= load_ppn;
            end
        end

        assign match[g] = present_q && (ppn_q == look_ppn);
    end

    // lowest index wins when two descriptors hold the same page
    always_comb begin
        hit_frame = '0;
        for (int f = NF - 1; f >= 0; f--) begin
            if (match[f]) hit_frame = FIDX_W'(f);
        end
        hit = |match;
    end

endmodule

// File: rtl/snoop_line_attrs.sv
module snoop_line_attrs
    import snoop_pkg::*;
#(
    parameter int NF     = 8,
    parameter int LPP    = 64,
    parameter int FIDX_W = 3,
    parameter int LIDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [FIDX_W-1:0] load_frame,
    input  logic              upd_en,
    input  logic [FIDX_W-1:0] upd_frame,
    input  logic [LIDX_W-1:0] upd_line,
    input  logic              upd_v,
    input  logic              upd_x,
    input  logic              upd_o,
    input  req_kind_e         snp_kind,
    input  logic [FIDX_W-1:0] snp_frame,
    input  logic [LIDX_W-1:0] snp_line,
    input  logic [FIDX_W-1:0] rd_frame,
    input  logic [LIDX_W-1:0] rd_line,
    output logic              rd_v,
    output logic              rd_x,
    output logic              page_any_v,
    output logic              page_any_o
);

    logic [NF-1:0][LPP-1:0] v_all, x_all, o_all;

    for (genvar g = 0; g < NF; g++) begin : g_frame
        logic [LPP-1:0] v_q, x_q, o_q;

        // order inside the process: mirror write, snoop change, load clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= '0;
                x_q <= '0;
                o_q <= '0;
            end else begin
                if (upd_en && upd_frame == FIDX_W'(g)) begin
                    v_q[upd_line] <= upd_v;
                    x_q[upd_line] <= upd_x;
                    o_q[upd_line] <= upd_o;
                end
                if (snp_frame == FIDX_W'(g)) begin
                    unique case (snp_kind)
                        REQ_LINE_INV: begin
                            v_q[snp_line] <= 1'b0;
                            x_q[snp_line] <= 1'b0;
                            o_q[snp_line] <= 1'b0;
                        end
                        REQ_LINE_SHARE: x_q[snp_line] <= 1'b0;
                        REQ_PAGE_INV: begin
                            v_q <= '0;
                            x_q <= '0;
                            o_q <= '0;
                        end
                        default: ;
                    endcase
                end
                if (load_en && load_frame == FIDX_W'(g)) begin
                    v_q <= '0;
                    x_q <= '0;
                    o_q <= '0;
                end
            end
        end

        assign v_all[g] = v_q;
        assign x_all[g] = x_q;
        assign o_all[g] = o_q;
    end

    assign rd_v       = v_all[rd_frame][rd_line];
    assign rd_x       = x_all[rd_frame][rd_line];
    assign page_any_v = |v_all[rd_frame];
    assign page_any_o = |o_all[rd_frame];

endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
    import snoop_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_OFS_W = 10,
    parameter int LINE_OFS_W = 4,
    parameter int NUM_FRAMES = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load_en,
    input  logic [$clog2(NUM_FRAMES)-1:0]    load_frame,
    input  logic [ADDR_W-PAGE_OFS_W-1:0]     load_ppn,
    input  logic                             upd_en,
    input  logic [$clog2(NUM_FRAMES)-1:0]    upd_frame,
    input  logic [PAGE_OFS_W-LINE_OFS_W-1:0] upd_line,
    input  logic                             upd_v,
    input  logic                             upd_x,
    input  logic                             upd_o,
    input  logic                             bus_as,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic                             bus_cc,
    input  logic                             bus_wr,
    input  logic                             bus_inv,
    output logic                             rsp_valid,
    output logic                             cs_o,
    output logic                             req_valid,
    output logic [1:0]                       req_kind,
    output logic [$clog2(NUM_FRAMES)-1:0]    req_frame,
    output logic [PAGE_OFS_W-LINE_OFS_W-1:0] req_line
);

    localparam int FIDX_W = $clog2(NUM_FRAMES);
    localparam int LIDX_W = PAGE_OFS_W - LINE_OFS_W;
    localparam int LPP    = 1 << LIDX_W;
    localparam int PPN_W  = ADDR_W - PAGE_OFS_W;

    logic [PPN_W-1:0]  look_ppn;
    logic [LIDX_W-1:0] look_line;
    logic              pg_hit;
    logic [FIDX_W-1:0] pg_frame;
    logic              ln_v, ln_x, any_v, any_o;
    logic              cs_d;
    req_kind_e         kind_d, snp_kind;

    snp_state_e        state_q, state_d;
    logic              cs_q;
    req_kind_e         kind_q;
    logic [FIDX_W-1:0] frame_q;
    logic [LIDX_W-1:0] line_q;

    assign look_ppn  = bus_addr[ADDR_W-1:PAGE_OFS_W];
    assign look_line = bus_addr[PAGE_OFS_W-1:LINE_OFS_W];

    snoop_tag_cam #(.NF(NUM_FRAMES), .PPN_W(PPN_W), .FIDX_W(FIDX_W)) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_frame (load_frame),
        .load_ppn   (load_ppn),
        .look_ppn   (look_ppn),
        .hit        (pg_hit),
        .hit_frame  (pg_frame)
    );

    snoop_line_attrs #(.NF(NUM_FRAMES), .LPP(LPP), .FIDX_W(FIDX_W), .LIDX_W(LIDX_W)) u_attrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_frame (load_frame),
        .upd_en     (upd_en),
        .upd_frame  (upd_frame),
        .upd_line   (upd_line),
        .upd_v      (upd_v),
        .upd_x      (upd_x),
        .upd_o      (upd_o),
        .snp_kind   (snp_kind),
        .snp_frame  (pg_frame),
        .snp_line   (look_line),
        .rd_frame   (pg_frame),
        .rd_line    (look_line),
        .rd_v       (ln_v),
        .rd_x       (ln_x),
        .page_any_v (any_v),
        .page_any_o (any_o)
    );

    // lookup: page first, then line; decide answer and attribute action
    always_comb begin
        cs_d   = 1'b0;
        kind_d = REQ_NONE;
        if (pg_hit) begin
            if (bus_inv) begin
                kind_d = REQ_PAGE_INV;
            end else if (bus_cc) begin
                cs_d = ln_v;
                if (ln_v && bus_wr)       kind_d = REQ_LINE_INV;
                else if (ln_v && ln_x)    kind_d = REQ_LINE_SHARE;
            end else begin
                cs_d = any_o || (bus_wr && any_v);
            end
        end
        snp_kind = bus_as ? kind_d : REQ_NONE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (bus_as)  state_d = ST_RESPOND;
            ST_RESPOND: if (!bus_as) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_q    <= 1'b0;
            kind_q  <= REQ_NONE;
            frame_q <= '0;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            if (bus_as) begin
                cs_q    <= cs_d;
                kind_q  <= kind_d;
                frame_q <= pg_frame;
                line_q  <= (kind_d == REQ_PAGE_INV) ? '0 : look_line;
            end
        end
    end

    always_comb begin
        rsp_valid = (state_q == ST_RESPOND);
        cs_o      = rsp_valid && cs_q;
        req_valid = rsp_valid && (kind_q != REQ_NONE);
        req_kind  = req_valid ? kind_q : REQ_NONE;
        req_frame = frame_q;
        req_line  = line_q;
    end

endmodule

// File: rtl/snoop_responder_chk.sv
module snoop_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_as,
    input logic       bus_cc,
    input logic       bus_inv,
    input logic       rsp_valid,
    input logic       cs_o,
    input logic       req_valid,
    input logic [1:0] req_kind
);

    assert_rsp_follows_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |=> rsp_valid);

    assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as |=> !rsp_valid);

    assert_multi_line_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as && !bus_cc && !bus_inv) |=> !req_valid);

    assert_line_req_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as && bus_cc && !bus_inv) |=> (req_kind != 2'd3));

    assert_inv_no_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as && bus_inv) |=> (!cs_o && (!req_valid || req_kind == 2'd3)));

endmodule

bind snoop_responder snoop_responder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_as    (bus_as),
    .bus_cc    (bus_cc),
    .bus_inv   (bus_inv),
    .rsp_valid (rsp_valid),
    .cs_o      (cs_o),
    .req_valid (req_valid),
    .req_kind  (req_kind)
);

// File: tb/snoop_responder_tb.sv
`timescale 1ns/1ps
module snoop_responder_tb;

    localparam int AW = 32, POW = 10, LOW = 4, NF = 8;
    localparam int FW = 3, LW = POW - LOW, LPP = 1 << LW, PW = AW - POW;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          load_en = 0, upd_en = 0, upd_v = 0, upd_x = 0, upd_o = 0;
    logic [FW-1:0] load_frame = 0, upd_frame = 0;
    logic [PW-1:0] load_ppn = 0;
    logic [LW-1:0] upd_line = 0;
    logic          bus_as = 0, bus_cc = 0, bus_wr = 0, bus_inv = 0;
    logic [AW-1:0] bus_addr = 0;
    logic          rsp_valid, cs_o, req_valid;
    logic [1:0]    req_kind;
    logic [FW-1:0] req_frame;
    logic [LW-1:0] req_line;

    snoop_responder #(.ADDR_W(AW), .PAGE_OFS_W(POW), .LINE_OFS_W(LOW), .NUM_FRAMES(NF)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_frame(load_frame), .load_ppn(load_ppn),
        .upd_en(upd_en), .upd_frame(upd_frame), .upd_line(upd_line),
        .upd_v(upd_v), .upd_x(upd_x), .upd_o(upd_o),
        .bus_as(bus_as), .bus_addr(bus_addr), .bus_cc(bus_cc), .bus_wr(bus_wr), .bus_inv(bus_inv),
        .rsp_valid(rsp_valid), .cs_o(cs_o), .req_valid(req_valid), .req_kind(req_kind),
        .req_frame(req_frame), .req_line(req_line)
    );

    // reference model
    logic [PW-1:0] m_tag [NF];
    bit            m_pres [NF];
    bit            m_v [NF][LPP];
    bit            m_x [NF][LPP];
    bit            m_o [NF][LPP];

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int f = 0; f < NF; f++) begin
            m_tag[f] = '0; m_pres[f] = 0;
            for (int l = 0; l < LPP; l++) begin m_v[f][l] = 0; m_x[f][l] = 0; m_o[f][l] = 0; end
        end
    endtask

    task automatic idle();
        load_en = 0; upd_en = 0; bus_as = 0; bus_cc = 0; bus_wr = 0; bus_inv = 0;
    endtask

    // one clock: predict from pre-state, update model, clock, compare
    task automatic tick();
        bit          hit = 0, e_cs = 0, anyv = 0, anyo = 0;
        int          mf = 0, e_kind = 0, e_line = 0;
        int          ln = int'(bus_addr[POW-1:LOW]);
        string       lab;
        for (int f = 0; f < NF; f++)
            if (!hit && m_pres[f] && m_tag[f] == bus_addr[AW-1:POW]) begin hit = 1; mf = f; end
        if (hit) for (int l = 0; l < LPP; l++) begin anyv |= m_v[mf][l]; anyo |= m_o[mf][l]; end
        lab = bus_inv ? "R9" : (bus_cc ? "R5" : "R6");
        if (bus_as && hit) begin
            if (bus_inv) e_kind = 3;
            else if (bus_cc) begin
                e_cs = m_v[mf][ln];
                e_line = ln;
                if (m_v[mf][ln] && bus_wr) e_kind = 1;
                else if (m_v[mf][ln] && m_x[mf][ln]) e_kind = 2;
            end else e_cs = anyo || (bus_wr && anyv);
        end
        // R4 then R10 then R3 ordering
        if (upd_en) begin
            m_v[upd_frame][upd_line] = upd_v; m_x[upd_frame][upd_line] = upd_x; m_o[upd_frame][upd_line] = upd_o;
        end
        if (bus_as && e_kind == 1) begin m_v[mf][ln] = 0; m_x[mf][ln] = 0; m_o[mf][ln] = 0; end
        if (bus_as && e_kind == 2) m_x[mf][ln] = 0;
        if (bus_as && e_kind == 3)
            for (int l = 0; l < LPP; l++) begin m_v[mf][l] = 0; m_x[mf][l] = 0; m_o[mf][l] = 0; end
        if (load_en) begin
            m_tag[load_frame] = load_ppn; m_pres[load_frame] = 1;
            for (int l = 0; l < LPP; l++) begin
                m_v[load_frame][l] = 0; m_x[load_frame][l] = 0; m_o[load_frame][l] = 0;
            end
        end
        begin
            bit as_was = bus_as;
            @(posedge clk);
            @(negedge clk);
            chk(rsp_valid == as_was, "R2 rsp_valid", rsp_valid, as_was);
            if (as_was) begin
                chk(cs_o == e_cs, {lab, " cs_o"}, cs_o, e_cs);
                chk(req_kind == 2'(e_kind) && req_valid == (e_kind != 0),
                    (e_kind == 1) ? "R7 req_kind" : (e_kind == 2) ? "R8 req_kind" : {lab, " req_kind"},
                    req_kind, e_kind);
                if (e_kind != 0) begin
                    chk(req_frame == FW'(mf), "R11 req_frame", req_frame, mf);
                    chk(req_line == LW'(e_line), "R9 req_line", req_line, e_line);
                end
            end
        end
    endtask

    task automatic snoop(input int ppn, input int ln, input bit cc, input bit wr, input bit inv);
        bus_as = 1; bus_addr = {PW'(ppn), LW'(ln), LOW'(0)}; bus_cc = cc; bus_wr = wr; bus_inv = inv;
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset outputs
        chk(!rsp_valid && !cs_o && !req_valid, "R1 reset outputs", {rsp_valid, cs_o, req_valid}, 0);
        rst_n = 1;
        // R1: empty array answers nothing
        idle(); snoop(22'h101, 3, 1, 1, 0); tick();
        idle(); snoop(22'h101, 3, 0, 1, 0); tick();
        // R3: load with same-cycle mirror write to that frame; load wins
        idle(); load_en = 1; load_frame = 2; load_ppn = 22'h101;
        upd_en = 1; upd_frame = 2; upd_line = 5; upd_v = 1; upd_x = 1; upd_o = 1; tick();
        idle(); snoop(22'h101, 5, 1, 0, 0); tick();
        // R4: fill line, same-cycle snoop sees old state
        idle(); upd_en = 1; upd_frame = 2; upd_line = 5; upd_v = 1; upd_x = 1; upd_o = 0;
        snoop(22'h101, 5, 1, 0, 0); tick();
        // R8: read hit exclusive downgrades, then no request
        idle(); snoop(22'h101, 5, 1, 0, 0); tick();
        idle(); snoop(22'h101, 5, 1, 0, 0); tick();
        // R6: multi-line read vs write
        idle(); snoop(22'h101, 0, 0, 0, 0); tick();
        idle(); snoop(22'h101, 0, 0, 1, 0); tick();
        // R10: mirror write and single-line write on same line
        idle(); upd_en = 1; upd_frame = 2; upd_line = 5; upd_v = 1; upd_x = 0; upd_o = 1;
        snoop(22'h101, 5, 1, 1, 0); tick();
        idle(); snoop(22'h101, 5, 0, 1, 0); tick();
        // R11: duplicate page, lowest frame; R9 page invalidate
        idle(); load_en = 1; load_frame = 6; load_ppn = 22'h101; tick();
        idle(); upd_en = 1; upd_frame = 2; upd_line = 9; upd_v = 1; upd_o = 1; upd_x = 0; tick();
        idle(); snoop(22'h101, 9, 1, 0, 1); tick();
        idle(); snoop(22'h101, 9, 0, 1, 0); tick();
        idle(); snoop(22'h1ff, 9, 1, 0, 1); tick();
        // constrained random with back-to-back strobes
        for (int i = 0; i < 4000; i++) begin
            idle();
            if ($urandom % 100 < 6) begin
                load_en = 1; load_frame = FW'($urandom % NF); load_ppn = PW'(22'h100 + $urandom % 6);
            end
            if ($urandom % 100 < 45) begin
                upd_en = 1; upd_frame = FW'($urandom % NF); upd_line = LW'($urandom % 8);
                upd_v = ($urandom % 4) != 0; upd_x = $urandom % 2; upd_o = $urandom % 3 == 0;
            end
            if ($urandom % 100 < 55)
                snoop(22'h100 + $urandom % 7, $urandom % 8, $urandom % 2, $urandom % 2,
                      ($urandom % 100) < 6);
            tick();
        end
        idle(); tick();
        report();
        $finish;
    end

endmodule